// File: doc/BRIEF.md
# USB Endpoint Receive FIFO Controller

This block is the receive buffer of a single USB function endpoint. The USB side pushes payload bytes one per cycle and then marks the end of a packet. A finished packet becomes a data set. Firmware reads the bytes of the oldest data set through a byte port and then hands the set back with a one-shot command. Two data sets are kept and used in alternation, so one packet can be read while the next one arrives.

A small 8-bit control register carries three bits that firmware can program. Bit 7 is a flush command. Bit 4 is a read-done command. Bit 3 selects isochronous mode. Both command bits clear themselves. Each command reads back as 1 for one cycle and takes effect at the edge that clears it. The status outputs are:
- an empty flag
- one valid flag per data set
- a start-overflow flag, for a byte that was dropped
- an end-overflow flag, for a packet that was dropped
- a data-toggle bit, which flips on every packet that is accepted

Flush returns every flag, pointer and packet length to its reset value. It does not change the data-toggle bit or the isochronous mode bit.

Top module: `usb_rx_fifo_ctl`

## Requirements
- R1: After reset the empty flag is 1. Both valid flags, both overflow flags, the data-toggle bit and every bit of the control read value are 0.
- R2: Bytes of committed packets come out of the read port in write order. The oldest valid data set is always read first, and the two sets are used in alternation.
- R3: An end-of-packet mark arrives while the set being written is still valid. The end-overflow flag becomes 1, the packet is discarded, and both valid flags keep their values.
- R4: A byte arrives when the current packet already holds DEPTH bytes, or when no data set is free. The byte is dropped and the start-overflow flag becomes 1.
- R5: A read-done command is given on a set whose bytes have all been read. The valid flag of that set clears. The empty flag is 1 when no set is valid.
- R6: A read-done command has no effect on the valid flags while either overflow flag is 1.
- R7: A read-done command has no effect when the FIFO is empty. It also has no effect when the oldest set still has unread bytes.
- R8: A flush sets the empty flag and clears both valid flags and both overflow flags. It returns the read and write pointers to the start, so the next packet is read back from its first byte.
- R9: A flush changes neither the isochronous mode bit nor the data-toggle bit.
- R10: The control read value has flush at bit 7, read-done at bit 4 and isochronous mode at bit 3, and reads 0 in every other bit. Each command bit reads 1 for exactly the one cycle after it is written, and then reads 0.
- R11: When a flush and a read-done command execute in the same cycle, the flush wins. A USB byte written in that cycle is also dropped.
- R12: The data-toggle bit flips on each packet that is accepted. It does not flip on a discarded packet.
- R13: Only a control write changes the isochronous mode bit. The bit takes the value of write-data bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_wr | input | 1 | USB byte strobe |
| usb_wdata | input | DATA_W | USB byte |
| usb_commit | input | 1 | End-of-packet mark |
| fw_rd | input | 1 | Firmware read strobe |
| fw_rdata | output | DATA_W | Current byte of the oldest set |
| fw_rd_avail | output | 1 | An unread byte is present |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control read value |
| st_empty | output | 1 | No data set is valid |
| st_set_valid | output | NSETS | Per-set valid flags |
| st_start_ovf | output | 1 | Byte-dropped flag |
| st_end_ovf | output | 1 | Packet-dropped flag |
| st_seq | output | 1 | Data-toggle bit |
| st_iso | output | 1 | Isochronous mode bit |

## Verification
A flush and a read-done command can execute in the same cycle, and a USB byte can arrive in that cycle too. The bench provokes this with one control write that sets bit 7 and bit 4 together, and drives a marked byte during the cycle in which both commands are active. It judges the flush the winner when all of the following hold:
- the set that had been read is gone, together with every other flag;
- the data-toggle bit is unchanged;
- the next packet reads back from its own first byte, and the marked byte never appears in the scoreboard.

// File: rtl/usb_rxf_pkg.sv
package usb_rxf_pkg;
   localparam int CTL_W         = 8;
   localparam int CTL_FLUSH_BIT = 7;
   localparam int CTL_RDONE_BIT = 4;
   localparam int CTL_ISO_BIT   = 3;

   typedef struct packed {
      logic flush;
      logic rdone;
      logic iso;
   } ctl_state_t;
endpackage

// File: rtl/rxf_ctl_reg.sv
module rxf_ctl_reg
   import usb_rxf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             flush_go,
   output logic             rdone_go,
   output logic             iso_mode,
   output logic [CTL_W-1:0] ctl_rdata
);
   ctl_state_t st_q;
   logic       unused_wbits;

   assign unused_wbits = ^{ctl_wdata[6:5], ctl_wdata[2:0]};

   // Command bits live for one cycle; iso is held until rewritten.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q.flush <= ctl_wr && ctl_wdata[CTL_FLUSH_BIT];
         st_q.rdone <= ctl_wr && ctl_wdata[CTL_RDONE_BIT];
         if (ctl_wr) st_q.iso <= ctl_wdata[CTL_ISO_BIT];
      end
   end

   assign flush_go = st_q.flush;
   assign rdone_go = st_q.rdone;
   assign iso_mode = st_q.iso;

   always_comb begin
      ctl_rdata                = '0;
      ctl_rdata[CTL_FLUSH_BIT] = st_q.flush;
      ctl_rdata[CTL_RDONE_BIT] = st_q.rdone;
      ctl_rdata[CTL_ISO_BIT]   = st_q.iso;
   end

   AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_go && !(ctl_wr && ctl_wdata[CTL_FLUSH_BIT])) |=> !flush_go); // R10
   AST_ISO_FW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(iso_mode)); // R13
endmodule

// File: rtl/rxf_set_tracker.sv
module rxf_set_tracker #(
   parameter int NSETS = 2,
   parameter int DEPTH = 16,
   localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_go,
   input  logic              rdone_go,
   input  logic              usb_wr,
   input  logic              usb_commit,
   input  logic              fw_rd,
   output logic              wr_accept,
   output logic [SET_W-1:0]  wr_set,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SET_W-1:0]  rd_set,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_avail,
   output logic [NSETS-1:0]  set_valid,
   output logic              start_ovf,
   output logic              end_ovf,
   output logic              seq
);
   logic [NSETS-1:0] valid_q;
   logic [CNT_W-1:0] len_q [NSETS];
   logic [SET_W-1:0] wr_set_q, rd_set_q;
   logic [CNT_W-1:0] wr_cnt_q, rd_cnt_q;
   logic             sovf_q, eovf_q, seq_q;

   logic             wr_room, commit_ok, commit_bad, rd_take, rdone_ok;
   logic [CNT_W-1:0] commit_len;

   function automatic logic [SET_W-1:0] next_set(input logic [SET_W-1:0] s);
      return (s == SET_W'(NSETS - 1)) ? '0 : s + 1'b1;
   endfunction

   assign wr_room    = !valid_q[wr_set_q] && (wr_cnt_q < CNT_W'(DEPTH));
   assign wr_accept  = usb_wr && wr_room && !flush_go;
   assign commit_ok  = usb_commit && !valid_q[wr_set_q] && !flush_go;
   assign commit_bad = usb_commit && valid_q[wr_set_q] && !flush_go;
   assign commit_len = wr_cnt_q + CNT_W'(wr_accept);
   assign rd_avail   = valid_q[rd_set_q] && (rd_cnt_q < len_q[rd_set_q]);
   assign rd_take    = fw_rd && rd_avail && !flush_go;
   assign rdone_ok   = rdone_go && !flush_go && !sovf_q && !eovf_q &&
                       valid_q[rd_set_q] && (rd_cnt_q == len_q[rd_set_q]);

   for (genvar i = 0; i < NSETS; i++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
            len_q[i]   <= '0;
         end else if (flush_go) begin
            valid_q[i] <= 1'b0;
            len_q[i]   <= '0;
         end else if (commit_ok && (wr_set_q == SET_W'(i))) begin
            valid_q[i] <= 1'b1;
            len_q[i]   <= commit_len;
         end else if (rdone_ok && (rd_set_q == SET_W'(i))) begin
            valid_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_set_q <= '0;
         rd_set_q <= '0;
         wr_cnt_q <= '0;
         rd_cnt_q <= '0;
         sovf_q   <= 1'b0;
         eovf_q   <= 1'b0;
         seq_q    <= 1'b0;
      end else if (flush_go) begin
         wr_set_q <= '0;
         rd_set_q <= '0;
         wr_cnt_q <= '0;
         rd_cnt_q <= '0;
         sovf_q   <= 1'b0;
         eovf_q   <= 1'b0;
      end else begin
         if (usb_wr && !wr_room) sovf_q <= 1'b1;
         if (commit_bad) eovf_q <= 1'b1;
         if (commit_ok) begin
            wr_set_q <= next_set(wr_set_q);
            seq_q    <= ~seq_q;
         end
         if (usb_commit) wr_cnt_q <= '0;
         else if (wr_accept) wr_cnt_q <= wr_cnt_q + 1'b1;
         if (rdone_ok) begin
            rd_set_q <= next_set(rd_set_q);
            rd_cnt_q <= '0;
         end else if (rd_take) begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
         end
      end
   end

   assign wr_set    = wr_set_q;
   assign rd_set    = rd_set_q;
   assign wr_addr   = wr_cnt_q[ADDR_W-1:0];
   assign rd_addr   = rd_cnt_q[ADDR_W-1:0];
   assign set_valid = valid_q;
   assign start_ovf = sovf_q;
   assign end_ovf   = eovf_q;
   assign seq       = seq_q;

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_go |=> (valid_q == '0 && !sovf_q && !eovf_q && wr_cnt_q == '0 && rd_cnt_q == '0)); // R8
   AST_FLUSH_KEEPS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      flush_go |=> $stable(seq_q)); // R9
   AST_RDONE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rdone_go && (sovf_q || eovf_q) && !usb_commit && !flush_go) |=> $stable(valid_q)); // R6
   AST_END_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_commit && valid_q[wr_set_q] && !flush_go && !rdone_go) |=> (eovf_q && $stable(valid_q))); // R3
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int NSETS  = 2,
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_set,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] bank_rd [NSETS];

   for (genvar s = 0; s < NSETS; s++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_set == SET_W'(s))) mem[wr_addr] <= wr_data;
      end
      assign bank_rd[s] = mem[rd_addr];
   end

   assign rd_data = bank_rd[rd_set];
endmodule

// File: rtl/usb_rx_fifo_ctl.sv
module usb_rx_fifo_ctl
   import usb_rxf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int NSETS  = 2,
   localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usb_wr,
   input  logic [DATA_W-1:0] usb_wdata,
   input  logic              usb_commit,
   input  logic              fw_rd,
   output logic [DATA_W-1:0] fw_rdata,
   output logic              fw_rd_avail,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        ctl_rdata,
   output logic              st_empty,
   output logic [NSETS-1:0]  st_set_valid,
   output logic              st_start_ovf,
   output logic              st_end_ovf,
   output logic              st_seq,
   output logic              st_iso
);
   if (NSETS != 2) begin : g_bad_sets
      $error("usb_rx_fifo_ctl: ping-pong scheme needs NSETS == 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("usb_rx_fifo_ctl: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("usb_rx_fifo_ctl: DATA_W must be positive");
   end

   logic              flush_go, rdone_go, wr_accept;
   logic [SET_W-1:0]  wr_set, rd_set;
   logic [ADDR_W-1:0] wr_addr, rd_addr;

   rxf_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .flush_go  (flush_go),
      .rdone_go  (rdone_go),
      .iso_mode  (st_iso),
      .ctl_rdata (ctl_rdata)
   );

   rxf_set_tracker #(.NSETS(NSETS), .DEPTH(DEPTH)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_go   (flush_go),
      .rdone_go   (rdone_go),
      .usb_wr     (usb_wr),
      .usb_commit (usb_commit),
      .fw_rd      (fw_rd),
      .wr_accept  (wr_accept),
      .wr_set     (wr_set),
      .wr_addr    (wr_addr),
      .rd_set     (rd_set),
      .rd_addr    (rd_addr),
      .rd_avail   (fw_rd_avail),
      .set_valid  (st_set_valid),
      .start_ovf  (st_start_ovf),
      .end_ovf    (st_end_ovf),
      .seq        (st_seq)
   );

   rxf_store #(.NSETS(NSETS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .wr_en   (wr_accept),
      .wr_set  (wr_set),
      .wr_addr (wr_addr),
      .wr_data (usb_wdata),
      .rd_set  (rd_set),
      .rd_addr (rd_addr),
      .rd_data (fw_rdata)
   );

   assign st_empty = ~|st_set_valid;

   AST_EMPTY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      fw_rd_avail |-> !st_empty); // R5
endmodule

// File: tb/usb_rx_fifo_ctl_bench.sv
`timescale 1ns/1ps
module usb_rx_fifo_ctl_bench;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;
   localparam int NSETS  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              usb_wr = 1'b0, usb_commit = 1'b0, fw_rd = 1'b0, ctl_wr = 1'b0;
   logic [DATA_W-1:0] usb_wdata = '0;
   logic [7:0]        ctl_wdata = '0;
   logic [DATA_W-1:0] fw_rdata;
   logic              fw_rd_avail;
   logic [7:0]        ctl_rdata;
   logic              st_empty, st_start_ovf, st_end_ovf, st_seq, st_iso;
   logic [NSETS-1:0]  st_set_valid;

   int n_tests = 0, n_fail = 0;
   logic [DATA_W-1:0] exp_q [$];
   logic model_seq = 1'b0;
   logic model_iso = 1'b0;
   logic [7:0] seen;

   always #2.5 clk = ~clk;

   usb_rx_fifo_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NSETS(NSETS)) u_usb_rx_fifo_ctl (
      .clk(clk), .rst_n(rst_n), .usb_wr(usb_wr), .usb_wdata(usb_wdata),
      .usb_commit(usb_commit), .fw_rd(fw_rd), .fw_rdata(fw_rdata),
      .fw_rd_avail(fw_rd_avail), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .st_empty(st_empty), .st_set_valid(st_set_valid),
      .st_start_ovf(st_start_ovf), .st_end_ovf(st_end_ovf), .st_seq(st_seq),
      .st_iso(st_iso)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // Monitor: pops the scoreboard on every byte the design hands out (R2)
   always @(negedge clk) begin
      if (rst_n && fw_rd && fw_rd_avail) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected byte", int'(fw_rdata), 0);
         end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(fw_rdata == e, "R2", "read byte", int'(fw_rdata), int'(e));
         end
      end
   end

   // Driver: writes n bytes then a commit; pushes expected bytes when accepted
   task automatic send_pkt(input int n, input logic [7:0] base,
                           input int keep, input bit accept);
      for (int i = 0; i < n; i++) begin
         usb_wr = 1'b1;
         usb_wdata = base + 8'(i);
         if (accept && i < keep) exp_q.push_back(base + 8'(i));
         step();
      end
      usb_wr = 1'b0;
      usb_commit = 1'b1;
      step();
      usb_commit = 1'b0;
      if (accept) model_seq = ~model_seq;
   endtask

   task automatic read_n(input int n);
      fw_rd = 1'b1;
      repeat (n) step();
      fw_rd = 1'b0;
   endtask

   // Control write; 'seen' is the read value in the cycle the command is live
   task automatic ctl_cmd(input logic [7:0] v);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      step();
      ctl_wr = 1'b0;
      seen = ctl_rdata;
      step();
   endtask

   function automatic logic [7:0] iso_bits();
      return model_iso ? 8'h08 : 8'h00;
   endfunction

   initial begin
      #(200000 * 5);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      chk(st_empty == 1'b1, "R1", "empty after reset", st_empty, 1);
      chk(st_set_valid == '0 && !st_start_ovf && !st_end_ovf && !st_seq, "R1",
          "flags after reset", {st_set_valid, st_start_ovf, st_end_ovf, st_seq}, 0);
      chk(ctl_rdata == 8'h00, "R1", "control read after reset", ctl_rdata, 0);
      rst_n = 1'b1;
      step();

      // R13 iso set by firmware; R10 bit position
      model_iso = 1'b1;
      ctl_cmd(8'h08);
      chk(st_iso == 1'b1 && ctl_rdata == 8'h08, "R13", "iso set", ctl_rdata, 8'h08);
      model_iso = 1'b0;
      ctl_cmd(8'h00);
      chk(st_iso == 1'b0, "R13", "iso cleared", st_iso, 0);

      // R12 / R2: two packets fill both sets
      send_pkt(4, 8'h10, 4, 1'b1);
      chk(st_set_valid == 2'b01 && !st_empty, "R2", "first set valid", st_set_valid, 2'b01);
      chk(st_seq == model_seq, "R12", "toggle after first packet", st_seq, model_seq);
      send_pkt(3, 8'h40, 3, 1'b1);
      chk(st_set_valid == 2'b11, "R2", "both sets valid", st_set_valid, 2'b11);
      chk(st_seq == model_seq, "R12", "toggle after second packet", st_seq, model_seq);

      // R7 read-done before any byte read: ignored; R10 pulse
      ctl_cmd(8'h10);
      chk(seen == 8'h10, "R10", "read-done bit live one cycle", seen, 8'h10);
      chk(ctl_rdata == 8'h00, "R10", "read-done bit self-cleared", ctl_rdata, 0);
      chk(st_set_valid == 2'b11, "R7", "partial-read release ignored", st_set_valid, 2'b11);

      // R5 release after full read, oldest first
      read_n(4);
      ctl_cmd(8'h10);
      chk(st_set_valid == 2'b10, "R5", "first set released", st_set_valid, 2'b10);
      read_n(3);
      ctl_cmd(8'h10);
      chk(st_set_valid == 2'b00 && st_empty, "R5", "all released, empty", st_set_valid, 0);
      chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

      // R7 release on empty FIFO
      ctl_cmd(8'h10);
      chk(st_empty && st_set_valid == '0 && ctl_rdata == 8'h00, "R7",
          "release on empty ignored", {st_empty, st_set_valid}, 3'b100);

      // R4 byte beyond DEPTH dropped
      send_pkt(DEPTH + 1, 8'h80, DEPTH, 1'b1);
      chk(st_start_ovf == 1'b1, "R4", "start overflow set", st_start_ovf, 1);
      chk(st_set_valid == 2'b01, "R4", "truncated packet stored", st_set_valid, 2'b01);
      read_n(DEPTH + 2);
      chk(exp_q.size() == 0, "R4", "exactly DEPTH bytes delivered", exp_q.size(), 0);

      // R6 release blocked by overflow flag
      ctl_cmd(8'h10);
      chk(st_set_valid == 2'b01, "R6", "release refused under overflow", st_set_valid, 2'b01);

      // R9 / R8 flush keeps iso and toggle
      model_iso = 1'b1;
      ctl_cmd(8'h08);
      ctl_cmd(8'h88);
      chk(seen == 8'h88, "R10", "flush bit live one cycle", seen, 8'h88);
      chk(ctl_rdata == 8'h08, "R10", "flush bit self-cleared", ctl_rdata, 8'h08);
      chk(st_empty && st_set_valid == '0 && !st_start_ovf && !st_end_ovf, "R8",
          "flags after flush", {st_empty, st_set_valid, st_start_ovf, st_end_ovf}, 5'b10000);
      chk(st_iso == 1'b1, "R9", "iso kept by flush", st_iso, 1);
      chk(st_seq == model_seq, "R9", "toggle kept by flush", st_seq, model_seq);
      exp_q.delete();

      // R3 end overflow with both sets busy
      send_pkt(2, 8'hA0, 2, 1'b1);
      send_pkt(2, 8'hB0, 2, 1'b1);
      send_pkt(2, 8'hC0, 0, 1'b0);
      chk(st_end_ovf == 1'b1, "R3", "end overflow set", st_end_ovf, 1);
      chk(st_set_valid == 2'b11, "R3", "sets unchanged", st_set_valid, 2'b11);
      chk(st_seq == model_seq, "R12", "no toggle on discarded packet", st_seq, model_seq);
      read_n(2);
      chk(exp_q.size() == 2, "R3", "discard kept stored data", exp_q.size(), 2);
      ctl_cmd(iso_bits() | 8'h80);
      exp_q.delete();

      // R8 pointers reset: next packet reads from its first byte
      send_pkt(3, 8'h50, 3, 1'b1);
      read_n(3);
      chk(exp_q.size() == 0, "R8", "packet after flush read in full", exp_q.size(), 0);

      // R11 flush + release + USB byte in the same cycle
      ctl_wr = 1'b1;
      ctl_wdata = iso_bits() | 8'h90;
      step();
      ctl_wr = 1'b0;
      usb_wr = 1'b1;
      usb_wdata = 8'hEE;
      step();
      usb_wr = 1'b0;
      chk(st_empty && st_set_valid == '0, "R11", "flush won over release",
          {st_empty, st_set_valid}, 3'b100);
      chk(st_seq == model_seq, "R11", "toggle unchanged", st_seq, model_seq);
      send_pkt(2, 8'h60, 2, 1'b1);
      read_n(2);
      chk(exp_q.size() == 0, "R11", "byte during flush dropped", exp_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule